// File: doc/BRIEF.md
# Split-Table Binary to Packed BCD Converter

This block turns a 16-bit unsigned binary word into five packed BCD digits covering 0 to 65535. It has no iteration and no shift-and-add loop. The lowest input bit goes straight to the lowest bit of the units digit. Bits 7 to 15 select a word in a 512-entry constant table, and bits 1 to 6 select a word in a 64-entry constant table. Bits 13 to 15 also select a 3-bit entry in an 8-entry table, which gives the base count of ten-thousands.

The 64-entry table holds its decimal digits with 6 already added to each one. Because of that, every decimal digit adder is a plain 4-bit binary add followed by a choice of subtracting 6 or nothing. The carry out of the binary add makes that choice. The digit adders are chained from units to thousands. The ten-thousands digit is then formed by a small binary adder that sums the base count, a wrap flag from the 512-entry table and the carry out of the thousands digit. All table contents are computed from constant functions when the design elaborates.

One register stage sits on the output, so a result appears one clock after its input is sampled. The block is meant to feed decimal displays, reports or decimal datapaths.

Top module: `bcd16_split_conv`

## Requirements
- R1: While `rst_n` is low, `bcd_o` reads all zeros.
- R2: `bcd_o` changes only at a rising clock edge, and it shows the conversion of the `bin_i` value sampled at the previous rising edge (one cycle of latency).
- R3: `bcd_o` holds the decimal value of `bin_i`, with the units digit in bits 3:0, tens in 7:4, hundreds in 11:8, thousands in 15:12 and ten-thousands in 19:16.
- R4: Every 4-bit digit of `bcd_o` lies in the range 0 to 9.
- R5: Bit 0 of `bcd_o` equals bit 0 of the converted input.
- R6: The ten-thousands digit never exceeds 6, and input 65535 gives 0x65535.
- R7: Decimal carries ripple through every digit: 9999 gives 0x09999 and 10000 gives 0x10000.
- R8: Any input with only bits 0 to 6 set (0 to 127) converts correctly. This is the path through the excess-6 table, including its hundreds bit.
- R9: Any input with bits 0 to 6 clear (a multiple of 128) converts correctly. This is the path through the 512-entry table together with its wrap flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the output register updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| bin_i | input | 16 | Unsigned binary value to convert |
| bcd_o | output | 20 | Packed BCD result, five digits, units in the low nibble |

## Verification
A wrong table word or a wrong -6/0 choice shows up at the ports one cycle after the offending input is applied. It appears as a digit that is wrong by six or ten, a digit above 9, or a missing carry into the next digit. These faults depend on the input pattern, so only some codes expose any given one. For that reason every one of the 65536 input codes is applied and checked at the register output in the cycle after it is driven. The walks over the lower and upper groups alone each isolate one table path.

// File: rtl/bcd16_split_pkg.sv
package bcd16_split_pkg;
  localparam int BIN_W    = 16;
  localparam int DIG_W    = 4;
  localparam int NDIG     = 5;
  localparam int BCD_W    = NDIG * DIG_W;
  localparam int N_ADD    = NDIG - 1;
  localparam int LO_LSB   = 1;
  localparam int HI_LSB   = 7;
  localparam int LO_BITS  = HI_LSB - LO_LSB;
  localparam int HI_BITS  = BIN_W - HI_LSB;
  localparam int TOP_BITS = 3;
  localparam int TOP_LSB  = BIN_W - TOP_BITS;
  localparam int LO_DEPTH = 1 << LO_BITS;
  localparam int HI_DEPTH = 1 << HI_BITS;
  localparam int TOP_DEPTH = 1 << TOP_BITS;
  // upper word: wrap flag, thousands, hundreds, tens, units[3:1]
  localparam int UP_W     = 1 + 3 * DIG_W + (DIG_W - 1);
  // lower word: hundreds bit, tens+6, units+6
  localparam int LO_W     = 1 + 2 * DIG_W;
  localparam int TOP_W    = 3;
  localparam int XS_BIAS  = 6;
  localparam int TENK     = 10000;

  typedef logic [DIG_W-1:0] digit_t;

  function automatic logic [BCD_W-1:0] digits_of(input int unsigned v);
    logic [BCD_W-1:0] r;
    int unsigned t;
    t = v;
    r = '0;
    for (int i = 0; i < NDIG; i++) begin
      r[DIG_W*i +: DIG_W] = DIG_W'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  // ten-thousands already contained in the three top input bits
  function automatic logic [TOP_W-1:0] top_entry(input int unsigned k);
    return TOP_W'((k << TOP_LSB) / TENK);
  endfunction

  function automatic logic [UP_W-1:0] upper_entry(input int unsigned idx);
    int unsigned v, rem;
    logic        wrap;
    logic [BCD_W-1:0] d;
    v    = idx << HI_LSB;
    rem  = v - TENK * int'(top_entry(idx >> (HI_BITS - TOP_BITS)));
    wrap = (rem >= TENK);
    if (wrap) rem = rem - TENK;
    d = digits_of(rem);
    return {wrap, d[4*DIG_W-1:1]};
  endfunction

  function automatic logic [LO_W-1:0] lower_entry(input int unsigned idx);
    logic [BCD_W-1:0] d;
    digit_t tx, ux;
    d  = digits_of(idx << LO_LSB);
    tx = d[2*DIG_W-1:DIG_W] + digit_t'(XS_BIAS);
    ux = d[DIG_W-1:0] + digit_t'(XS_BIAS);
    return {d[2*DIG_W], tx, ux};
  endfunction
endpackage

// File: rtl/bcd16_split_tables.sv
module bcd16_split_tables
  import bcd16_split_pkg::*;
(
  input  logic [HI_BITS-1:0]  hi_idx,
  input  logic [LO_BITS-1:0]  lo_idx,
  input  logic [TOP_BITS-1:0] top_idx,
  output logic [UP_W-1:0]     up_word,
  output logic [LO_W-1:0]     lo_word,
  output logic [TOP_W-1:0]    top_cnt
);
  logic [UP_W-1:0]  up_rom  [HI_DEPTH];
  logic [LO_W-1:0]  lo_rom  [LO_DEPTH];
  logic [TOP_W-1:0] top_rom [TOP_DEPTH];

  for (genvar g = 0; g < HI_DEPTH; g++) begin : g_up
    assign up_rom[g] = upper_entry(g);
  end
  for (genvar g = 0; g < LO_DEPTH; g++) begin : g_lo
    assign lo_rom[g] = lower_entry(g);
  end
  for (genvar g = 0; g < TOP_DEPTH; g++) begin : g_top
    assign top_rom[g] = top_entry(g);
  end

  assign up_word = up_rom[hi_idx];
  assign lo_word = lo_rom[lo_idx];
  assign top_cnt = top_rom[top_idx];
endmodule

// File: rtl/bcd16_xs6_digit_add.sv
module bcd16_xs6_digit_add
  import bcd16_split_pkg::*;
(
  input  logic [DIG_W-1:0] a_plain,
  input  logic [DIG_W-1:0] b_xs6,
  input  logic             cin,
  output logic [DIG_W-1:0] sum,
  output logic             cout
);
  logic [DIG_W:0] raw;

  assign raw  = {1'b0, a_plain} + {1'b0, b_xs6} + {{DIG_W{1'b0}}, cin};
  assign cout = raw[DIG_W];
  // no binary carry means the bias is still inside the result
  assign sum  = cout ? raw[DIG_W-1:0] : raw[DIG_W-1:0] - DIG_W'(XS_BIAS);
endmodule

// File: rtl/bcd16_split_conv.sv
module bcd16_split_conv
  import bcd16_split_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BIN_W-1:0]  bin_i,
  output logic [BCD_W-1:0]  bcd_o
);
  logic [UP_W-1:0]  up_word;
  logic [LO_W-1:0]  lo_word;
  logic [TOP_W-1:0] top_cnt;

  logic [N_ADD-1:0][DIG_W-1:0] dig_a;
  logic [N_ADD-1:0][DIG_W-1:0] dig_b;
  logic [N_ADD-1:0][DIG_W-1:0] dig_r;
  logic [N_ADD:0]              dig_c;
  logic [DIG_W-1:0]            dig_top;
  logic [BCD_W-1:0]            bcd_next;

  bcd16_split_tables u_tab (
    .hi_idx  (bin_i[BIN_W-1:HI_LSB]),
    .lo_idx  (bin_i[HI_LSB-1:LO_LSB]),
    .top_idx (bin_i[BIN_W-1:TOP_LSB]),
    .up_word (up_word),
    .lo_word (lo_word),
    .top_cnt (top_cnt)
  );

  always_comb begin
    dig_a[0] = {up_word[DIG_W-2:0], 1'b0};
    dig_a[1] = up_word[2*DIG_W-2:DIG_W-1];
    dig_a[2] = up_word[3*DIG_W-2:2*DIG_W-1];
    dig_a[3] = up_word[4*DIG_W-2:3*DIG_W-1];
    dig_b[0] = lo_word[DIG_W-1:0];
    dig_b[1] = lo_word[2*DIG_W-1:DIG_W];
    dig_b[2] = DIG_W'(XS_BIAS) + {{(DIG_W-1){1'b0}}, lo_word[2*DIG_W]};
    dig_b[3] = DIG_W'(XS_BIAS);
  end

  assign dig_c[0] = 1'b0;

  for (genvar g = 0; g < N_ADD; g++) begin : g_dig
    bcd16_xs6_digit_add u_add (
      .a_plain (dig_a[g]),
      .b_xs6   (dig_b[g]),
      .cin     (dig_c[g]),
      .sum     (dig_r[g]),
      .cout    (dig_c[g+1])
    );
  end

  assign dig_top = {{(DIG_W-TOP_W){1'b0}}, top_cnt}
                 + {{(DIG_W-1){1'b0}}, up_word[UP_W-1]}
                 + {{(DIG_W-1){1'b0}}, dig_c[N_ADD]};

  always_comb begin
    bcd_next = {dig_top, dig_r[3], dig_r[2], dig_r[1], dig_r[0]};
    bcd_next[0] = bin_i[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcd_o <= '0;
    else        bcd_o <= bcd_next;
  end
endmodule

// File: rtl/bcd16_split_conv_chk.sv
module bcd16_split_conv_chk
  import bcd16_split_pkg::*;
(
  input logic                        clk,
  input logic                        rst_n,
  input logic [BIN_W-1:0]            bin_i,
  input logic [BCD_W-1:0]            bcd_o,
  input logic [N_ADD-1:0][DIG_W-1:0] dig_a,
  input logic [N_ADD-1:0][DIG_W-1:0] dig_r,
  input logic [N_ADD:0]              dig_c
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  function automatic int unsigned dec_value(input logic [BCD_W-1:0] x);
    int unsigned acc;
    acc = 0;
    for (int i = NDIG - 1; i >= 0; i--) acc = acc * 10 + int'(x[DIG_W*i +: DIG_W]);
    return acc;
  endfunction

  function automatic logic nibbles_ok(input logic [BCD_W-1:0] x);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NDIG; i++) if (x[DIG_W*i +: DIG_W] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  p_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> dec_value(bcd_o) == int'($past(bin_i)));

  p_nibble_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
    nibbles_ok(bcd_o));

  p_lsb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> bcd_o[0] == $past(bin_i[0]));

  p_top_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bcd_o[BCD_W-1:BCD_W-DIG_W] <= 4'd6);

  p_carry_shrinks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dig_c[1] |-> dig_r[0] <= dig_a[0]);

  p_nocarry_grows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dig_c[4] |-> dig_r[3] >= dig_a[3]);

  p_digit_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dig_r[1] <= 4'd9 && dig_r[2] <= 4'd9);
endmodule

bind bcd16_split_conv bcd16_split_conv_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .bin_i (bin_i),
  .bcd_o (bcd_o),
  .dig_a (dig_a),
  .dig_r (dig_r),
  .dig_c (dig_c)
);

// File: tb/bcd16_split_conv_tb.sv
module bcd16_split_conv_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bin_i = '0;
  logic [19:0] bcd_o;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bcd16_split_conv u_dut (.clk(clk), .rst_n(rst_n), .bin_i(bin_i), .bcd_o(bcd_o));

  localparam int NVEC = 13;
  localparam logic [35:0] VEC [NVEC] = '{
    {16'd0,     20'h00000}, {16'd1,     20'h00001}, {16'd9,     20'h00009},
    {16'd10,    20'h00010}, {16'd99,    20'h00099}, {16'd127,   20'h00127},
    {16'd128,   20'h00128}, {16'd8192,  20'h08192}, {16'd9999,  20'h09999},
    {16'd10000, 20'h10000}, {16'd40960, 20'h40960}, {16'd65408, 20'h65408},
    {16'd65535, 20'h65535}
  };

  function automatic logic [19:0] ref_bcd(input int unsigned v);
    logic [19:0] r;
    int unsigned q;
    q = v;
    for (int i = 0; i < 5; i++) begin
      r[4*i +: 4] = 4'(q % 10);
      q = q / 10;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [19:0] got, input logic [19:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  // drive at falling edge, result registered at next rising edge, sample at following falling edge
  task automatic apply(input logic [15:0] v);
    @(negedge clk);
    bin_i = v;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset holds zero even with a nonzero input present
    bin_i = 16'd4321;
    repeat (3) @(negedge clk);
    check("R1 reset", bcd_o, 20'h00000);
    rst_n = 1'b1;

    // R2: one-cycle latency, no change before the edge
    apply(16'd4321);
    check("R2 after edge", bcd_o, 20'h04321);
    bin_i = 16'd777;
    #2;
    check("R2 before edge", bcd_o, 20'h04321);
    @(negedge clk);
    check("R2 next", bcd_o, 20'h00777);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][35:20]);
      check("R3 table", bcd_o, VEC[i][19:0]);
    end

    apply(16'd65535);
    check("R6 max", bcd_o, 20'h65535);
    apply(16'd9999);
    check("R7 all nines", bcd_o, 20'h09999);
    apply(16'd10000);
    check("R7 ripple", bcd_o, 20'h10000);

    for (int v = 0; v < 128; v++) begin
      apply(16'(v));
      check("R8 low group", bcd_o, ref_bcd(v));
    end
    for (int v = 0; v < 512; v++) begin
      apply(16'(v << 7));
      check("R9 high group", bcd_o, ref_bcd(v << 7));
    end

    for (int v = 0; v < 65536; v++) begin
      apply(16'(v));
      check("R3 exhaustive", bcd_o, ref_bcd(v));
      checks++;
      if (bcd_o[0] !== v[0]) begin
        failures++;
        $display("FAIL R5 lsb got=%b expected=%b", bcd_o[0], v[0]);
      end
      for (int d = 0; d < 5; d++) begin
        checks++;
        if (bcd_o[4*d +: 4] > 4'd9) begin
          failures++;
          $display("FAIL R4 digit%0d got=%h expected<=9", d, bcd_o[4*d +: 4]);
        end
      end
      checks++;
      if (bcd_o[19:16] > 4'd6) begin
        failures++;
        $display("FAIL R6 top got=%h expected<=6", bcd_o[19:16]);
      end
    end

    finish_run();
  end
endmodule